// File: doc/BRIEF.md
# Multi-Mode PWM Timer/Counter

This block is an 8-bit timer/counter with one waveform output channel. A 3-bit mode input selects how the counter moves, where its ceiling (TOP) comes from, when the two compare values take effect, and at which point the overflow flag fires. Four behaviours are available: free-running counting, clear-on-compare, single-slope fast PWM and dual-slope phase-correct PWM. The counter only moves on a one-cycle clock-enable pulse, so any prescaler can sit outside the block.

Two compare values, A and B, are written through simple write strobes. In the PWM modes each write lands in a shadow register. It is copied into the active register at a mode-specific point in the count cycle, so a duty-cycle change never produces a glitch. Compare B drives the waveform pin, according to a 2-bit output-mode input. Compare A can act as TOP. Sticky flags record overflow and both compare matches until a clear strobe removes them.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count, the waveform pin, the active and shadow compare values and all three flags are zero, and the phase-correct direction is upward.
- R2: The count, flags, pin and buffered compare loads change only on a cycle where `tick` is high. A compare write still lands in its register without a tick.
- R3: Mode values 0, 4 and 6 count 0x00 up to 0xFF and wrap. Overflow is flagged on the tick taken at 0xFF. Compare writes take effect at once.
- R4: Mode 2 uses active compare A as TOP. The tick taken at TOP returns the count to 0. Compare writes take effect at once. Overflow is flagged only on a tick taken at 0xFF.
- R5: Mode 3 (TOP = 0xFF) and mode 7 (TOP = active compare A) wrap to 0 on the tick taken at TOP and flag overflow on that same tick. Shadow values are copied to the active registers on that wrap tick.
- R6: Mode 1 (TOP = 0xFF) and mode 5 (TOP = active compare A) count up to TOP, then down to 0, then up again. Each end value is present for exactly one tick. Shadow values are copied on the tick taken at TOP. Overflow is flagged on the tick taken at 0 while counting down.
- R7: In a buffered mode, several writes before the update point leave only the last value, and that value takes effect only at the update point.
- R8: The compare-A and compare-B flags set on a tick taken when the count equals the active A or B value. The flags are sticky. `flag_clr` bit 0 clears overflow, bit 1 clears compare A and bit 2 clears compare B. A set on the same cycle as a clear wins.
- R9: In modes 0, 2, 4 and 6 a compare-B match acts on the pin according to the output mode: 01 toggles the pin, 10 clears it and 11 sets it.
- R10: In fast PWM, output mode 10 clears the pin on a compare-B match and sets it on the wrap tick. Output mode 11 does the opposite. When both happen on one tick, the wrap action wins.
- R11: In phase-correct PWM, output mode 10 clears the pin on a match taken while the next step goes up (including the tick at 0) and sets it on a match taken while the next step goes down (including the tick at TOP). Output mode 11 does the opposite.
- R12: In phase-correct PWM, when active compare B equals TOP and output-mode bit 1 is set, the tick at TOP applies the down-count action: output mode 10 sets the pin and holds it high for the whole cycle.
- R13: `wave_oe` is low, and `wave_out` is forced low, for output mode 00 in every mode and for output mode 01 in the PWM modes. Otherwise `wave_oe` is high and `wave_out` follows the pin register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock-enable pulse that advances the counter |
| mode | input | 3 | Counting mode select |
| com_b | input | 2 | Output mode for the compare-B pin |
| ocr_a_wr | input | 1 | Write strobe for compare A |
| ocr_a_data | input | 8 | Write data for compare A |
| ocr_b_wr | input | 1 | Write strobe for compare B |
| ocr_b_data | input | 8 | Write data for compare B |
| flag_clr | input | 3 | Flag clear strobes: bit 0 overflow, bit 1 compare A, bit 2 compare B |
| count | output | 8 | Current counter value |
| wave_out | output | 1 | Waveform pin value |
| wave_oe | output | 1 | Pin enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmpa_flag | output | 1 | Sticky compare-A match flag |
| cmpb_flag | output | 1 | Sticky compare-B match flag |

## Verification
The tight spot is a compare-B match that lands on the same tick as the counter's turning point. In fast PWM the match and the wrap both want to drive the pin. In phase-correct mode the match at TOP must take the down-count action. The bench sets compare B to TOP: first with A and B both still zero in mode 7, then with B loaded to TOP in mode 5. It checks that the pin holds high through a whole period and that no clear slips through. A second collision, where an overflow set meets a clear strobe on one cycle, is driven at the 0xFF tick of normal mode. The flag must read set afterwards.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        K_NORMAL = 2'd0,
        K_CTC    = 2'd1,
        K_FAST   = 2'd2,
        K_PHASE  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        UPD_NOW    = 2'd0,
        UPD_TOP    = 2'd1,
        UPD_BOTTOM = 2'd2
    } upd_e;

    typedef struct packed {
        kind_e kind;
        logic  top_from_a;
        upd_e  upd;
    } mode_cfg_t;

    typedef struct packed {
        logic ovf;
        logic wrap;
        logic turn_top;
        logic step_up;
    } cnt_ev_t;

    function automatic mode_cfg_t decode_mode(input logic [2:0] m);
        mode_cfg_t c;
        case (m)
            3'd1:    c = '{kind: K_PHASE, top_from_a: 1'b0, upd: UPD_TOP};
            3'd2:    c = '{kind: K_CTC,   top_from_a: 1'b1, upd: UPD_NOW};
            3'd3:    c = '{kind: K_FAST,  top_from_a: 1'b0, upd: UPD_BOTTOM};
            3'd5:    c = '{kind: K_PHASE, top_from_a: 1'b1, upd: UPD_TOP};
            3'd7:    c = '{kind: K_FAST,  top_from_a: 1'b1, upd: UPD_BOTTOM};
            default: c = '{kind: K_NORMAL, top_from_a: 1'b0, upd: UPD_NOW};
        endcase
        return c;
    endfunction

    function automatic logic is_pwm(input kind_e k);
        return (k == K_FAST) || (k == K_PHASE);
    endfunction

endpackage

// File: rtl/pwm_timer_count.sv
module pwm_timer_count
    import pwm_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  kind_e        kind,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output cnt_ev_t      ev
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_q, cnt_d;
    logic         up_q, up_d;
    cnt_ev_t      ev_raw;

    always_comb begin
        cnt_d  = cnt_q + ONE;
        up_d   = 1'b1;
        ev_raw = '0;
        case (kind)
            K_PHASE: begin
                up_d = up_q;
                ev_raw.step_up = (up_q && (cnt_q < top)) || (cnt_q == '0);
                if (up_q) begin
                    if (cnt_q >= top) begin
                        ev_raw.turn_top = 1'b1;
                        if (top == '0) begin
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q - ONE;
                            up_d  = 1'b0;
                        end
                    end
                end else if (cnt_q == '0) begin
                    ev_raw.ovf = 1'b1;
                    up_d       = 1'b1;
                    cnt_d      = (top == '0) ? '0 : ONE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            K_FAST: begin
                ev_raw.step_up = 1'b1;
                if (cnt_q == top) begin
                    ev_raw.wrap = 1'b1;
                    ev_raw.ovf  = 1'b1;
                    cnt_d       = '0;
                end
            end
            K_CTC: begin
                ev_raw.step_up = 1'b1;
                ev_raw.ovf     = (cnt_q == MAXV);
                if (cnt_q == top) begin
                    ev_raw.wrap = 1'b1;
                    cnt_d       = '0;
                end
            end
            default: begin
                ev_raw.step_up = 1'b1;
                ev_raw.ovf     = (cnt_q == MAXV);
                ev_raw.wrap    = (cnt_q == MAXV);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (tick) begin
            cnt_q <= cnt_d;
            up_q  <= up_d;
        end
    end

    assign cnt = cnt_q;
    assign ev  = tick ? ev_raw : '0;

endmodule

// File: rtl/pwm_timer_ocr.sv
module pwm_timer_ocr
    import pwm_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  upd_e         upd,
    input  logic         turn_top,
    input  logic         wrap,
    output logic [W-1:0] act
);
    logic [W-1:0] shadow_q, act_q;
    logic         load_pt;

    assign load_pt = ((upd == UPD_TOP) && turn_top) ||
                     ((upd == UPD_BOTTOM) && wrap);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (wr) shadow_q <= wdata;
            if (wr && (upd == UPD_NOW)) act_q <= wdata;
            else if (load_pt)           act_q <= wr ? wdata : shadow_q;
        end
    end

    assign act = act_q;

endmodule

// File: rtl/pwm_timer_wave.sv
module pwm_timer_wave
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  kind_e      kind,
    input  logic [1:0] com,
    input  logic       match,
    input  logic       step_up,
    input  logic       wrap,
    output logic       pin,
    output logic       oe
);
    logic pin_q;

    assign oe = (com != 2'b00) && !((com == 2'b01) && is_pwm(kind));

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else begin
            case (kind)
                K_FAST: begin
                    if (com[1]) begin
                        if (wrap)       pin_q <= ~com[0];
                        else if (match) pin_q <= com[0];
                    end
                end
                K_PHASE: begin
                    if (com[1] && match) pin_q <= step_up ? com[0] : ~com[0];
                end
                default: begin
                    if (match) begin
                        case (com)
                            2'b01:   pin_q <= ~pin_q;
                            2'b10:   pin_q <= 1'b0;
                            2'b11:   pin_q <= 1'b1;
                            default: pin_q <= pin_q;
                        endcase
                    end
                end
            endcase
        end
    end

    assign pin = oe & pin_q;

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import pwm_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [2:0]   mode,
    input  logic [1:0]   com_b,
    input  logic         ocr_a_wr,
    input  logic [W-1:0] ocr_a_data,
    input  logic         ocr_b_wr,
    input  logic [W-1:0] ocr_b_data,
    input  logic [2:0]   flag_clr,
    output logic [W-1:0] count,
    output logic         wave_out,
    output logic         wave_oe,
    output logic         ovf_flag,
    output logic         cmpa_flag,
    output logic         cmpb_flag
);
    localparam int           NCH  = 2;
    localparam logic [W-1:0] MAXV = '1;

    mode_cfg_t              cfg;
    cnt_ev_t                ev;
    logic [W-1:0]           cnt, top_val;
    logic [NCH-1:0]         wr_v, hit_v;
    logic [NCH-1:0][W-1:0]  wd_v, act_v;
    logic                   ovf_q, cma_q, cmb_q;

    assign cfg     = decode_mode(mode);
    assign wr_v    = {ocr_b_wr, ocr_a_wr};
    assign wd_v    = {ocr_b_data, ocr_a_data};
    assign top_val = cfg.top_from_a ? act_v[0] : MAXV;

    pwm_timer_count #(.W(W)) u_count (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .kind (cfg.kind),
        .top  (top_val),
        .cnt  (cnt),
        .ev   (ev)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_timer_ocr #(.W(W)) u_ocr (
            .clk      (clk),
            .rst      (rst),
            .wr       (wr_v[g]),
            .wdata    (wd_v[g]),
            .upd      (cfg.upd),
            .turn_top (ev.turn_top),
            .wrap     (ev.wrap),
            .act      (act_v[g])
        );
        assign hit_v[g] = tick && (cnt == act_v[g]);
    end

    pwm_timer_wave u_wave (
        .clk     (clk),
        .rst     (rst),
        .kind    (cfg.kind),
        .com     (com_b),
        .match   (hit_v[1]),
        .step_up (ev.step_up),
        .wrap    (ev.wrap),
        .pin     (wave_out),
        .oe      (wave_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            cma_q <= 1'b0;
            cmb_q <= 1'b0;
        end else begin
            ovf_q <= ev.ovf   | (ovf_q & ~flag_clr[0]);
            cma_q <= hit_v[0] | (cma_q & ~flag_clr[1]);
            cmb_q <= hit_v[1] | (cmb_q & ~flag_clr[2]);
        end
    end

    assign count     = cnt;
    assign ovf_flag  = ovf_q;
    assign cmpa_flag = cma_q;
    assign cmpb_flag = cmb_q;

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic [2:0]   mode,
    input logic [1:0]   com_b,
    input logic [2:0]   flag_clr,
    input logic [W-1:0] count,
    input logic         wave_out,
    input logic         wave_oe,
    input logic         ovf_flag,
    input logic         cmpa_flag,
    input logic         cmpb_flag
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));  // R2

    AST_IDLE_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ovf_flag) |=> !ovf_flag);  // R2

    AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == 3'd0) |=> (count == $past(count) + ONE));  // R3

    AST_FAST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == 3'd3 && count == MAXV) |=> (count == '0 && ovf_flag));  // R5

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == 3'd1 && count != '0 && count != MAXV)
        |=> (count == $past(count) + ONE || count == $past(count) - ONE));  // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr[0]) |=> ovf_flag);  // R8

    AST_CMPA_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cmpa_flag && !flag_clr[1]) |=> cmpa_flag);  // R8

    AST_CMPB_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cmpb_flag && !flag_clr[2]) |=> cmpb_flag);  // R8

    AST_PIN_OFF: assert property (@(posedge clk) disable iff (rst)
        (com_b == 2'b00) |-> (!wave_oe && !wave_out));  // R13

endmodule

bind pwm_timer8 pwm_timer8_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .mode      (mode),
    .com_b     (com_b),
    .flag_clr  (flag_clr),
    .count     (count),
    .wave_out  (wave_out),
    .wave_oe   (wave_oe),
    .ovf_flag  (ovf_flag),
    .cmpa_flag (cmpa_flag),
    .cmpb_flag (cmpb_flag)
);

// File: tb/pwm_timer8_test.sv
module pwm_timer8_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [1:0] com_b = 2'b00;
    logic       ocr_a_wr = 1'b0;
    logic [7:0] ocr_a_data = '0;
    logic       ocr_b_wr = 1'b0;
    logic [7:0] ocr_b_data = '0;
    logic [2:0] flag_clr = '0;
    logic [7:0] count;
    logic       wave_out, wave_oe, ovf_flag, cmpa_flag, cmpb_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pwm_timer8 #(.W(8)) uut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .mode       (mode),
        .com_b      (com_b),
        .ocr_a_wr   (ocr_a_wr),
        .ocr_a_data (ocr_a_data),
        .ocr_b_wr   (ocr_b_wr),
        .ocr_b_data (ocr_b_data),
        .flag_clr   (flag_clr),
        .count      (count),
        .wave_out   (wave_out),
        .wave_oe    (wave_oe),
        .ovf_flag   (ovf_flag),
        .cmpa_flag  (cmpa_flag),
        .cmpb_flag  (cmpb_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] m, input logic [1:0] c);
        @(negedge clk);
        rst = 1'b1; tick = 1'b0; flag_clr = '0; mode = m; com_b = c;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic write_a(input logic [7:0] v);
        @(negedge clk) begin ocr_a_wr = 1'b1; ocr_a_data = v; end
        @(negedge clk) ocr_a_wr = 1'b0;
    endtask

    task automatic write_b(input logic [7:0] v);
        @(negedge clk) begin ocr_b_wr = 1'b1; ocr_b_data = v; end
        @(negedge clk) ocr_b_wr = 1'b0;
    endtask

    task automatic clear_flags(input logic [2:0] m);
        @(negedge clk) flag_clr = m;
        @(negedge clk) flag_clr = '0;
    endtask

    task automatic t_reset_and_gate();
        do_reset(3'd0, 2'b00);
        check("R1 count", count, 0);
        check("R1 flags", {ovf_flag, cmpa_flag, cmpb_flag}, 0);
        check("R1 pin", wave_out, 0);
        check("R13 oe off", wave_oe, 0);
        repeat (6) @(negedge clk);
        check("R2 no tick", count, 0);
        ticks(3);
        check("R2 three ticks", count, 3);
    endtask

    task automatic t_normal();
        do_reset(3'd0, 2'b00);
        ticks(255);
        check("R3 at max", count, 255);
        check("R3 no ovf yet", ovf_flag, 0);
        @(negedge clk) begin tick = 1'b1; flag_clr = 3'b001; end
        @(negedge clk) begin tick = 1'b0; flag_clr = '0; end
        check("R3 wrap", count, 0);
        check("R8 set beats clear", ovf_flag, 1);
        clear_flags(3'b001);
        check("R8 cleared", ovf_flag, 0);
        do_reset(3'd4, 2'b00);
        ticks(3);
        check("R3 reserved mode counts", count, 3);
    endtask

    task automatic t_ctc();
        do_reset(3'd2, 2'b11);
        write_a(8'd5);
        write_b(8'd2);
        check("R2 write without tick", count, 0);
        ticks(2);
        check("R9 before match", wave_out, 0);
        ticks(1);
        check("R9 set on match", wave_out, 1);
        check("R13 oe on", wave_oe, 1);
        ticks(2);
        check("R4 at top", count, 5);
        ticks(1);
        check("R4 wrap at A", count, 0);
        check("R8 compare A flag", cmpa_flag, 1);
        check("R8 compare B flag", cmpb_flag, 1);
        check("R4 no ovf below max", ovf_flag, 0);
        com_b = 2'b01;
        ticks(3);
        check("R9 toggle", wave_out, 0);
    endtask

    task automatic t_fast();
        do_reset(3'd7, 2'b10);
        write_a(8'd9);
        write_b(8'd4);
        ticks(1);
        check("R5 wrap with top zero", count, 0);
        check("R5 ovf at top", ovf_flag, 1);
        check("R10 wrap beats match", wave_out, 1);
        clear_flags(3'b111);
        ticks(4);
        check("R5 loaded A", count, 4);
        check("R10 high before match", wave_out, 1);
        ticks(1);
        check("R10 clear on match", wave_out, 0);
        write_b(8'd6);
        write_b(8'd7);
        ticks(4);
        check("R5 at top 9", count, 9);
        check("R7 old B still active", wave_out, 0);
        check("R5 no ovf before top", ovf_flag, 0);
        ticks(1);
        check("R5 wrap", count, 0);
        check("R5 ovf", ovf_flag, 1);
        check("R10 set at wrap", wave_out, 1);
        ticks(7);
        check("R7 last write wins", wave_out, 1);
        ticks(1);
        check("R7 new B active", wave_out, 0);
    endtask

    task automatic t_phase();
        do_reset(3'd5, 2'b10);
        write_a(8'd4);
        write_b(8'd2);
        ticks(1);
        check("R6 top load", count, 0);
        ticks(4);
        check("R6 reach top", count, 4);
        check("R11 clear upward", wave_out, 0);
        ticks(1);
        check("R6 top held once", count, 3);
        ticks(2);
        check("R11 set downward", wave_out, 1);
        ticks(1);
        check("R6 bottom", count, 0);
        check("R6 no ovf before bottom tick", ovf_flag, 0);
        ticks(1);
        check("R6 bottom held once", count, 1);
        check("R6 ovf at bottom", ovf_flag, 1);
        write_b(8'd4);
        ticks(2);
        check("R7 B pending", wave_out, 0);
        ticks(8);
        check("R7 B updated at top", wave_out, 0);
        ticks(2);
        check("R12 set at top", wave_out, 1);
        check("R12 count", count, 3);
        ticks(7);
        check("R12 full period high", wave_out, 1);
        com_b = 2'b01;
        @(negedge clk);
        check("R13 reserved pwm output", wave_oe, 0);
        do_reset(3'd1, 2'b00);
        ticks(255);
        check("R6 mode 1 top", count, 255);
        ticks(1);
        check("R6 mode 1 turn", count, 254);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_and_gate();
        t_normal();
        t_ctc();
        t_fast();
        t_phase();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule